// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block brings DDR SDRAM from power-on to normal operation without software help. Once reset is released it steps through a fixed initialization program. That program opens with a NOP, followed by a long settling wait. It then issues a precharge-all, an extended mode write that enables the DLL, and a mode write that resets the DLL. Next come a second precharge-all, a run of auto-refreshes, and a final mode write without DLL reset. The block then switches the controller to normal mode and raises a completion flag.

Each command is broadcast to every populated rank. Populated ranks are found by walking a table of cumulative rank boundaries, given in units of 32 MB. Each command leaves on a valid/ready port as a 3-bit code and a host address. The address is the start of the target rank. For mode writes, the mode value is spread onto host address lines 13:3.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is asserted and just after it, `cmd_valid` is 0, `init_done` is 0 and `ctrl_mode` is 0.
- R2: Commands leave in this order of codes: NOP (1); precharge (2); extended mode write (4); mode write (3); precharge (2); eight auto-refreshes (6); mode write (3). No command with code 7 (normal) or 0 is ever presented.
- R3: The first mode write carries mode value 0x16A: burst length 4, interleaved, CAS latency 2.5, DLL reset. The last mode write carries 0x06A. The extended mode write carries 0x000. Mode bit 11 goes to address bit 13, and mode bits 9:0 go to address bits 12:3, so the two mode writes add offsets 0xB50 and 0x350. All other commands add offset 0.
- R4: Rank i takes boundary byte `rank_bound[8i+7:8i]`. A rank is populated when its boundary is greater than the boundary of rank i-1 (taken as 0 for rank 0). Each command goes once to each populated rank, in ascending rank order, at address (boundary of rank i-1) × 2^25 plus the mode offset.
- R5: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_code` and `cmd_addr` hold their values.
- R6: At least WAIT_CLKS clocks pass between the last NOP handshake and the first precharge handshake.
- R7: Between any two handshakes, `cmd_valid` stays 0 for at least `gap_cycles` clocks.
- R8: While a command is presented, `ctrl_mode` equals its code. After the last mode write, `ctrl_mode` becomes 7 with no command presented. `init_done` rises one clock later, stays high, and no further command appears.
- R9: With no populated rank, the sequence still reaches `init_done` and presents no command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rank_bound | input | NRANK*BW | Cumulative rank boundaries, 32 MB units, rank 0 in the low byte |
| gap_cycles | input | GAP_W | Minimum idle clocks between commands |
| cmd_ready | input | 1 | Command consumer accepts the presented command |
| cmd_valid | output | 1 | A command is presented |
| cmd_code | output | 3 | Command code |
| cmd_addr | output | BW+25 | Host address of the command |
| ctrl_mode | output | 3 | Code of the current controller mode |
| init_done | output | 1 | Initialization complete |

## Verification
The assertions assume that `rank_bound` and `gap_cycles` stay static from reset release until `init_done`. They make no assumption about `cmd_ready`, which may stall any command for any length of time. The stimulus sets both static inputs during reset and holds them for the whole run. It toggles `cmd_ready` at random on every cycle. Boundary tables include fully populated, empty, sparse and non-increasing layouts, plus random ones, with random gap lengths including zero.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_SELF_REF  = 3'd0,
    CMD_NOP       = 3'd1,
    CMD_PRECHARGE = 3'd2,
    CMD_MRS       = 3'd3,
    CMD_EMRS      = 3'd4,
    CMD_AUTO_REF  = 3'd6,
    CMD_NORMAL    = 3'd7
  } ddr_cmd_e;

  localparam int NUM_REFRESH = 8;
  localparam int REF_FIRST   = 5;
  localparam int MRS_FINAL   = REF_FIRST + NUM_REFRESH;
  localparam int NUM_STEPS   = MRS_FINAL + 2;
  localparam int RANK_SHIFT  = 25;

  localparam logic [11:0] MR_OPERATING = 12'h06A;
  localparam logic [11:0] MR_DLL_RESET = 12'h100;
  localparam logic [11:0] EMR_DLL_ON   = 12'h000;

  function automatic ddr_cmd_e step_cmd(input int s);
    if (s == 0)                            return CMD_NOP;
    else if (s == 1 || s == 4)             return CMD_PRECHARGE;
    else if (s == 2)                       return CMD_EMRS;
    else if (s == 3 || s == MRS_FINAL)     return CMD_MRS;
    else if (s >= REF_FIRST && s < MRS_FINAL) return CMD_AUTO_REF;
    else                                   return CMD_NORMAL;
  endfunction

  function automatic logic [11:0] step_mode(input int s);
    if (s == 2)              return EMR_DLL_ON;
    else if (s == 3)         return MR_OPERATING | MR_DLL_RESET;
    else if (s == MRS_FINAL) return MR_OPERATING;
    else                     return 12'h000;
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_rank_walk.sv
module ddr_init_rank_walk #(
  parameter int NRANK = 4,
  parameter int BW    = 8,
  parameter int IDX_W = 3
) (
  input  logic [NRANK*BW-1:0] bounds,
  input  logic [IDX_W-1:0]    from_idx,
  output logic                found,
  output logic [IDX_W-1:0]    sel_idx,
  output logic [BW-1:0]       sel_base
);

  logic [NRANK-1:0] eligible;
  logic [BW-1:0]    base_of [NRANK];

  for (genvar i = 0; i < NRANK; i++) begin : g_rank
    logic [BW-1:0] upper;
    assign upper = bounds[i*BW +: BW];
    if (i == 0) begin : g_first
      assign base_of[i] = '0;
    end else begin : g_next
      assign base_of[i] = bounds[(i-1)*BW +: BW];
    end
    assign eligible[i] = (upper > base_of[i]) && (IDX_W'(i) >= from_idx);
  end

  always_comb begin
    found    = 1'b0;
    sel_idx  = '0;
    sel_base = '0;
    for (int i = NRANK - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        found    = 1'b1;
        sel_idx  = IDX_W'(i);
        sel_base = base_of[i];
      end
    end
  end

endmodule

// File: rtl/ddr_init_addr_map.sv
module ddr_init_addr_map
  import ddr_init_pkg::*;
#(
  parameter int BW     = 8,
  parameter int ADDR_W = BW + RANK_SHIFT
) (
  input  ddr_cmd_e          code,
  input  logic [11:0]       mode,
  input  logic [BW-1:0]     base,
  output logic [ADDR_W-1:0] addr
);

  logic [13:0] offset;

  always_comb begin
    if (code == CMD_MRS || code == CMD_EMRS) offset = {mode[11], mode[9:0], 3'b000};
    else                                     offset = '0;
    addr = {base, {RANK_SHIFT{1'b0}}} | ADDR_W'(offset);
  end

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int NRANK     = 4,
  parameter int BW        = 8,
  parameter int GAP_W     = 8,
  parameter int WAIT_CLKS = 26600
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NRANK*BW-1:0]   rank_bound,
  input  logic [GAP_W-1:0]      gap_cycles,
  input  logic                  cmd_ready,
  output logic                  cmd_valid,
  output logic [2:0]            cmd_code,
  output logic [BW+RANK_SHIFT-1:0] cmd_addr,
  output logic [2:0]            ctrl_mode,
  output logic                  init_done
);

  localparam int ADDR_W = BW + RANK_SHIFT;
  localparam int IDX_W  = $clog2(NRANK + 1);
  localparam int STEP_W = $clog2(NUM_STEPS);
  localparam int WAIT_W = $clog2(WAIT_CLKS + 1);
  localparam int CNT_W  = (WAIT_W > GAP_W) ? WAIT_W : GAP_W;

  typedef enum logic [2:0] {
    ST_STEP, ST_SCAN, ST_ISSUE, ST_GAP, ST_WAIT, ST_FINISH, ST_DONE
  } seq_state_e;

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [IDX_W-1:0]  ridx_q, ridx_d;
  ddr_cmd_e          code_q, code_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  ddr_cmd_e          mode_q, mode_d;
  logic              done_q, done_d;

  ddr_cmd_e          cur_cmd;
  logic [11:0]       cur_mode;
  logic              walk_found;
  logic [IDX_W-1:0]  walk_idx;
  logic [BW-1:0]     walk_base;
  logic [ADDR_W-1:0] mapped_addr;
  logic              tmr_load, tmr_expired;
  logic [CNT_W-1:0]  tmr_val;

  assign cur_cmd  = step_cmd(int'(step_q));
  assign cur_mode = step_mode(int'(step_q));

  ddr_init_rank_walk #(.NRANK(NRANK), .BW(BW), .IDX_W(IDX_W)) u_walk (
    .bounds   (rank_bound),
    .from_idx (ridx_q),
    .found    (walk_found),
    .sel_idx  (walk_idx),
    .sel_base (walk_base)
  );

  ddr_init_addr_map #(.BW(BW), .ADDR_W(ADDR_W)) u_map (
    .code (cur_cmd),
    .mode (cur_mode),
    .base (walk_base),
    .addr (mapped_addr)
  );

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    ridx_d   = ridx_q;
    code_d   = code_q;
    addr_d   = addr_q;
    mode_d   = mode_q;
    done_d   = done_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_STEP: begin
        mode_d = cur_cmd;
        if (cur_cmd == CMD_NORMAL) begin
          state_d = ST_FINISH;
        end else begin
          ridx_d  = '0;
          state_d = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (walk_found) begin
          code_d  = cur_cmd;
          addr_d  = mapped_addr;
          ridx_d  = walk_idx + IDX_W'(1);
          state_d = ST_ISSUE;
        end else begin
          step_d = step_q + STEP_W'(1);
          if (cur_cmd == CMD_NOP) begin
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(WAIT_CLKS);
            state_d  = ST_WAIT;
          end else begin
            state_d = ST_STEP;
          end
        end
      end
      ST_ISSUE: begin
        if (cmd_ready) begin
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(gap_cycles);
          state_d  = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tmr_expired) state_d = ST_SCAN;
      end
      ST_WAIT: begin
        if (tmr_expired) state_d = ST_STEP;
      end
      ST_FINISH: begin
        done_d  = 1'b1;
        state_d = ST_DONE;
      end
      default: state_d = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STEP;
      step_q  <= '0;
      ridx_q  <= '0;
      code_q  <= CMD_NOP;
      addr_q  <= '0;
      mode_q  <= CMD_SELF_REF;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      ridx_q  <= ridx_d;
      code_q  <= code_d;
      addr_q  <= addr_d;
      mode_q  <= mode_d;
      done_q  <= done_d;
    end
  end

  assign cmd_valid = (state_q == ST_ISSUE);
  assign cmd_code  = code_q;
  assign cmd_addr  = addr_q;
  assign ctrl_mode = mode_q;
  assign init_done = done_q;

  // R5
  hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_addr)));

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cmd_code != 3'd7) && (cmd_code != 3'd0));

  // R8
  mode_tracks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (ctrl_mode == cmd_code));

  // R8
  done_after_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (ctrl_mode == 3'd7) && ($past(ctrl_mode) == 3'd7));

  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R8
  quiet_when_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !cmd_valid);

endmodule

// File: tb/ddr_init_seq_tb.sv
module ddr_init_seq_tb;

  localparam int NR    = 4;
  localparam int BWB   = 8;
  localparam int AW    = BWB + 25;
  localparam int WAITC = 2000;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NR*BWB-1:0] rank_bound;
  logic [7:0]      gap_cycles;
  logic            cmd_ready;
  logic            cmd_valid;
  logic [2:0]      cmd_code;
  logic [AW-1:0]   cmd_addr;
  logic [2:0]      ctrl_mode;
  logic            init_done;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ddr_init_seq #(.NRANK(NR), .BW(BWB), .GAP_W(8), .WAIT_CLKS(WAITC)) u_dut (
    .clk(clk), .rst_n(rst_n), .rank_bound(rank_bound), .gap_cycles(gap_cycles),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_addr(cmd_addr), .ctrl_mode(ctrl_mode), .init_done(init_done)
  );

  logic [2:0]    cap_code[$];
  logic [AW-1:0] cap_addr[$];
  int            cap_cyc[$];
  int            cyc = 0;
  logic          monitor_on = 1'b0;
  logic          prev_stall = 1'b0;
  logic [2:0]    prev_code, prev_mode;
  logic [AW-1:0] prev_addr;
  logic          prev_done = 1'b0;
  int            bad_hold, bad_track, bad_rise, bad_quiet;

  always @(negedge clk) begin
    cyc++;
    cmd_ready <= 1'b0;
    if (monitor_on) begin
      logic r;
      r = ($urandom % 4) != 0;
      cmd_ready <= r;
      if (prev_stall && !(cmd_valid && cmd_code == prev_code && cmd_addr == prev_addr)) bad_hold++;
      if (cmd_valid && ctrl_mode != cmd_code) bad_track++;
      if (init_done && !prev_done && prev_mode != 3'd7) bad_rise++;
      if (init_done && cmd_valid) bad_quiet++;
      if (cmd_valid && r) begin
        cap_code.push_back(cmd_code);
        cap_addr.push_back(cmd_addr);
        cap_cyc.push_back(cyc);
      end
      prev_stall = cmd_valid && !r;
      prev_code  = cmd_code;
      prev_addr  = cmd_addr;
      prev_mode  = ctrl_mode;
      prev_done  = init_done;
    end
  end

  function automatic logic [2:0] exp_code(int s);
    case (s)
      0: return 3'd1;
      1, 4: return 3'd2;
      2: return 3'd4;
      3, 13: return 3'd3;
      default: return 3'd6;
    endcase
  endfunction

  function automatic logic [11:0] exp_mode(int s);
    if (s == 3) return 12'h16A;
    if (s == 13) return 12'h06A;
    return 12'h000;
  endfunction

  function automatic logic [AW-1:0] exp_addr(logic [7:0] base, logic [2:0] c, logic [11:0] m);
    logic [AW-1:0] a;
    a = AW'(base) << 25;
    if (c == 3'd3 || c == 3'd4) a = a + AW'({m[11], m[9:0], 3'b000});
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [7:0] b0, b1, b2, b3, input logic [7:0] g, input string tag);
    logic [7:0] bnd[NR];
    logic [2:0]    e_code[$];
    logic [AW-1:0] e_addr[$];
    int pop;
    int n;
    int t;
    bnd[0] = b0; bnd[1] = b1; bnd[2] = b2; bnd[3] = b3;
    monitor_on = 1'b0;
    rst_n = 1'b0;
    rank_bound = {b3, b2, b1, b0};
    gap_cycles = g;
    cap_code.delete(); cap_addr.delete(); cap_cyc.delete();
    bad_hold = 0; bad_track = 0; bad_rise = 0; bad_quiet = 0;
    prev_stall = 1'b0; prev_done = 1'b0; prev_mode = 3'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!cmd_valid && !init_done && ctrl_mode == 3'd0, "R1", "reset outputs",
          {cmd_valid, init_done, ctrl_mode}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    pop = 0;
    for (int s = 0; s < 14; s++) begin
      for (int i = 0; i < NR; i++) begin
        logic [7:0] lo;
        lo = (i == 0) ? 8'd0 : bnd[i-1];
        if (bnd[i] > lo) begin
          e_code.push_back(exp_code(s));
          e_addr.push_back(exp_addr(lo, exp_code(s), exp_mode(s)));
          if (s == 0) pop++;
        end
      end
    end
    t = 0;
    while (!init_done && t < 40000) begin
      @(negedge clk);
      t++;
    end
    check(init_done, "R8", {tag, " completion before watchdog"}, init_done, 1);
    repeat (12) @(negedge clk);
    monitor_on = 1'b0;
    // R4 / R9 command count per populated ranks
    check(cap_code.size() == e_code.size(), pop == 0 ? "R9" : "R4",
          {tag, " command count"}, cap_code.size(), e_code.size());
    n = (cap_code.size() < e_code.size()) ? cap_code.size() : e_code.size();
    for (int k = 0; k < n; k++) begin
      check(cap_code[k] == e_code[k], "R2", {tag, " command code"}, cap_code[k], e_code[k]);
      check(cap_addr[k] == e_addr[k], "R3/R4", {tag, " command address"}, cap_addr[k], e_addr[k]);
    end
    // R6 settling wait after the NOPs
    if (pop > 0 && cap_cyc.size() > pop)
      check(cap_cyc[pop] - cap_cyc[pop-1] >= WAITC, "R6", {tag, " settle wait"},
            cap_cyc[pop] - cap_cyc[pop-1], WAITC);
    // R7 idle gap
    for (int k = 1; k < cap_cyc.size(); k++) begin
      if (cap_cyc[k] - cap_cyc[k-1] - 1 < int'(g))
        check(1'b0, "R7", {tag, " idle gap"}, cap_cyc[k] - cap_cyc[k-1] - 1, g);
    end
    check(1'b1, "R7", {tag, " idle gap"}, 0, 0);
    check(bad_hold == 0, "R5", {tag, " hold under stall"}, bad_hold, 0);
    check(bad_track == 0 && bad_rise == 0 && bad_quiet == 0, "R8",
          {tag, " mode tracking and completion"}, bad_track + bad_rise + bad_quiet, 0);
    check(ctrl_mode == 3'd7, "R8", {tag, " final mode"}, ctrl_mode, 7);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    cmd_ready = 1'b0;
    rank_bound = '0;
    gap_cycles = '0;
    run(8'd1, 8'd2, 8'd3, 8'd4, 8'd0, "full");
    run(8'd0, 8'd0, 8'd0, 8'd0, 8'd3, "empty");
    run(8'd0, 8'd2, 8'd2, 8'd5, 8'd1, "sparse");
    run(8'd4, 8'd2, 8'd6, 8'd6, 8'd2, "nonincreasing");
    run(8'd255, 8'd255, 8'd255, 8'd255, 8'd5, "top_boundary");
    for (int k = 0; k < 3; k++) begin
      run(8'($urandom % 8), 8'($urandom % 8), 8'($urandom % 8), 8'($urandom % 8),
          8'($urandom % 8), "random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20 - 100);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule